// File: doc/BRIEF.md
# Ripple-Carry ALU with Signed Less-Than

This block is a 32-bit combinational arithmetic logic unit. It is built from one-bit slices chained so that each slice's carry feeds the next. It computes bitwise AND, bitwise OR, addition, subtraction and a signed less-than test. Two control inputs select the function. A negate line inverts operand B inside every slice and also supplies the carry into bit 0, so a single adder serves both addition and subtraction (a + ~b + 1). A two-bit select then picks which per-slice value reaches the result.

For the less-than test, the top slice produces a set bit. This bit is the sign of the true difference, taken as the MSB sum XOR the signed overflow. It is wired back to the less input of bit 0. Every other slice's less input is tied low. The result is therefore 1 exactly when A is below B as signed numbers, even when the subtraction itself overflows. The block also reports the carry out of the top slice, a signed-overflow flag and an all-zero flag. It has no clock and no state; a surrounding pipeline registers its outputs.

Top module: `alu_ripple32`

## Requirements
- R1: With opSel = 0 and bNegate = 0, result equals opA AND opB bit for bit.
- R2: With opSel = 1 and bNegate = 0, result equals opA OR opB bit for bit.
- R3: With opSel = 2 and bNegate = 0, result equals (opA + opB) mod 2^32, and carryOut is bit 32 of the unsigned sum.
- R4: With opSel = 2 and bNegate = 1, result equals (opA - opB) mod 2^32, and carryOut is bit 32 of opA + ~opB + 1 (1 when opA >= opB unsigned).
- R5: With opSel = 3 and bNegate = 1, result[0] is 1 exactly when opA < opB as signed two's complement numbers, including cases where opA - opB overflows, and result[31:1] is 0.
- R6: overflow is 1 exactly when the adder's signed result has the wrong sign: two non-negative operands (after the optional B inversion) give a negative sum, or two negative ones give a non-negative sum. The flag reflects the adder for every opSel.
- R7: overflow is 0 when adding (bNegate = 0) operands of opposite sign, and when subtracting (bNegate = 1) operands of equal sign.
- R8: zero is 1 exactly when all 32 result bits are 0.
- R9: bNegate = 1 also applies to the logic operations: opSel = 0 gives opA AND NOT opB, and opSel = 1 gives opA OR NOT opB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| bNegate | input | 1 | Invert B in every slice and force the carry into bit 0 high |
| opSel | input | 2 | Result select: 0 AND, 1 OR, 2 adder sum, 3 less-than |
| result | output | 32 | Selected result |
| carryOut | output | 1 | Carry out of the top slice |
| overflow | output | 1 | Signed overflow of the adder |
| zero | output | 1 | All result bits are 0 |

## Verification
The hardest case is a less-than comparison whose subtraction overflows. Examples are minint against a positive value and maxint against a negative one. There the raw MSB of the difference gives the wrong answer, and only the overflow correction in the set bit yields the right one. Random operands almost never reach these cases. The stimulus therefore crosses every pair from a boundary set {0, 1, -1, maxint, minint, 0x55555555} with every control combination. A random sweep covers the general carry chains.

// File: rtl/alu_ripple_pkg.sv
`timescale 1ns/1ps
package alu_ripple_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } sel_e;

  typedef struct packed {
    logic bInvert;
    logic carryIn;
    sel_e resultSel;
  } alu_strobe_t;

  function automatic logic sumBit(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic carryBit(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic pickResult(input sel_e sel, input logic andV, input logic orV,
                                      input logic sumV, input logic lessV);
    logic r;
    case (sel)
      SEL_AND: r = andV;
      SEL_OR:  r = orV;
      SEL_SUM: r = sumV;
      default: r = lessV;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/alu_bit_slice.sv
`timescale 1ns/1ps
module alu_bit_slice
  import alu_ripple_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic bInvert,
  input  logic cin,
  input  logic less,
  input  sel_e resultSel,
  output logic result,
  output logic cout
);
  logic bEff;
  logic sumV;

  assign bEff   = bInvert ? ~b : b;
  assign sumV   = sumBit(a, bEff, cin);
  assign cout   = carryBit(a, bEff, cin);
  assign result = pickResult(resultSel, a & bEff, a | bEff, sumV, less);
endmodule

// File: rtl/alu_msb_slice.sv
`timescale 1ns/1ps
module alu_msb_slice
  import alu_ripple_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic bInvert,
  input  logic cin,
  input  logic less,
  input  sel_e resultSel,
  output logic result,
  output logic cout,
  output logic setOut,
  output logic ovfOut
);
  logic bEff;
  logic sumV;

  assign bEff   = bInvert ? ~b : b;
  assign sumV   = sumBit(a, bEff, cin);
  assign cout   = carryBit(a, bEff, cin);
  // signed overflow: carry into the sign bit differs from carry out of it
  assign ovfOut = cin ^ cout;
  // true sign of the difference, corrected for overflow
  assign setOut = sumV ^ ovfOut;
  assign result = pickResult(resultSel, a & bEff, a | bEff, sumV, less);
endmodule

// File: rtl/alu_ripple_ctrl.sv
`timescale 1ns/1ps
module alu_ripple_ctrl
  import alu_ripple_pkg::*;
(
  input  logic        bNegate,
  input  logic [1:0]  opSel,
  output alu_strobe_t strobe
);
  always_comb begin
    strobe.bInvert   = bNegate;
    strobe.carryIn   = bNegate;
    strobe.resultSel = sel_e'(opSel);
  end
endmodule

// File: rtl/alu_ripple_dp.sv
`timescale 1ns/1ps
module alu_ripple_dp
  import alu_ripple_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_strobe_t      strobe,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry;
  logic           setMsb;

  assign carry[0] = strobe.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == MSB) begin : g_top
      alu_msb_slice u_slice (
        .a         (opA[i]),
        .b         (opB[i]),
        .bInvert   (strobe.bInvert),
        .cin       (carry[i]),
        .less      (1'b0),
        .resultSel (strobe.resultSel),
        .result    (result[i]),
        .cout      (carry[i+1]),
        .setOut    (setMsb),
        .ovfOut    (overflow)
      );
    end else if (i == 0) begin : g_bottom
      alu_bit_slice u_slice (
        .a         (opA[i]),
        .b         (opB[i]),
        .bInvert   (strobe.bInvert),
        .cin       (carry[i]),
        .less      (setMsb),
        .resultSel (strobe.resultSel),
        .result    (result[i]),
        .cout      (carry[i+1])
      );
    end else begin : g_mid
      alu_bit_slice u_slice (
        .a         (opA[i]),
        .b         (opB[i]),
        .bInvert   (strobe.bInvert),
        .cin       (carry[i]),
        .less      (1'b0),
        .resultSel (strobe.resultSel),
        .result    (result[i]),
        .cout      (carry[i+1])
      );
    end
  end

  assign carryOut = carry[WIDTH];
  assign zero     = ~|result;
endmodule

// File: rtl/alu_ripple32.sv
`timescale 1ns/1ps
module alu_ripple32
  import alu_ripple_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             bNegate,
  input  logic [1:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero
);
  alu_strobe_t strobe;

  alu_ripple_ctrl u_ctrl (
    .bNegate (bNegate),
    .opSel   (opSel),
    .strobe  (strobe)
  );

  alu_ripple_dp #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow),
    .zero     (zero)
  );
endmodule

module alu_ripple32_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             bNegate,
  input logic [1:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             overflow,
  input logic             zero
);
  logic known;
  assign known = !$isunknown({opA, opB, bNegate, opSel, result, carryOut, overflow, zero});

  always_comb begin
    if (known) begin
      // R8
      zero_flag_chk: assert (zero == (result == '0))
        else $error("zero flag disagrees with result");
      // R5
      less_upper_chk: assert (!(opSel == 2'd3) || (result[WIDTH-1:1] == '0))
        else $error("less-than result has upper bits set");
      // R7
      no_overflow_chk: assert (!((!bNegate && (opA[WIDTH-1] != opB[WIDTH-1])) ||
                                 (bNegate && (opA[WIDTH-1] == opB[WIDTH-1]))) || !overflow)
        else $error("overflow raised where signs rule it out");
      // R6
      overflow_sign_chk: assert (!(overflow && opSel == 2'd2) || (result[WIDTH-1] != opA[WIDTH-1]))
        else $error("overflow with sum sign matching operand A");
      // R1
      and_op_chk: assert (!(opSel == 2'd0 && !bNegate) || (result == (opA & opB)))
        else $error("AND result mismatch");
    end
  end
endmodule

bind alu_ripple32 alu_ripple32_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu_ripple32.sv
`timescale 1ns/1ps
module tb_alu_ripple32;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         cout;
    logic         ovf;
    logic         zro;
    string        tag;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  always #10 clk = ~clk;

  logic [W-1:0] opA = '0, opB = '0;
  logic         bNegate = 0;
  logic [1:0]   opSel = 0;
  logic [W-1:0] result;
  logic         carryOut, overflow, zero;

  alu_ripple32 dut (
    .opA(opA), .opB(opB), .bNegate(bNegate), .opSel(opSel),
    .result(result), .carryOut(carryOut), .overflow(overflow), .zero(zero)
  );

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic neg, logic [1:0] sel);
    exp_t e;
    logic [W-1:0] bb;
    logic [W:0]   wide;
    logic [W+1:0] exact;
    bb    = neg ? ~b : b;
    wide  = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, neg};
    exact = {{2{a[W-1]}}, a} + {{2{bb[W-1]}}, bb} + {{(W+1){1'b0}}, neg};
    e.cout = wide[W];
    e.ovf  = exact[W] != exact[W-1];
    case (sel)
      2'd0: begin e.res = a & bb; e.tag = neg ? "R9" : "R1"; end
      2'd1: begin e.res = a | bb; e.tag = neg ? "R9" : "R2"; end
      2'd2: begin e.res = wide[W-1:0]; e.tag = neg ? "R4" : "R3"; end
      default: begin e.res = {{(W-1){1'b0}}, exact[W]}; e.tag = "R5"; end
    endcase
    e.zro = (e.res == '0);
    return e;
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic neg, logic [1:0] sel);
    @(posedge clk);
    #1;
    opA = a; opB = b; bNegate = neg; opSel = sel;
    q.push_back(model(a, b, neg, sel));
  endtask

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: a=%h b=%h neg=%0b sel=%0d actual=%h expected=%h",
               tag, what, opA, opB, bNegate, opSel, act, exp);
    end
  endtask

  // monitor: compares at the falling edge, inputs changed shortly after the rising edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "result", result, e.res);
      if (opSel == 2'd2) check(e.tag, "carryOut", {31'b0, carryOut}, {31'b0, e.cout});
      check("R6 R7", "overflow", {31'b0, overflow}, {31'b0, e.ovf});
      check("R8", "zero", {31'b0, zero}, {31'b0, e.zro});
    end
  end

  logic [W-1:0] edges [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h5555_5555};

  initial begin
    repeat (3) @(posedge clk);
    rst = 0;
    // reset-state style check: all-zero inputs give zero AND result, R1 and R8
    drive('0, '0, 0, 2'd0);
    // R5: overflowing comparisons
    drive(32'h8000_0000, 32'h0000_0001, 1, 2'd3);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 2'd3);
    drive(32'h0000_0001, 32'h8000_0000, 1, 2'd3);
    // R6: positive + positive overflow, negative + negative overflow
    drive(32'h7FFF_FFFF, 32'h0000_0001, 0, 2'd2);
    drive(32'h8000_0000, 32'h8000_0000, 0, 2'd2);
    // R4: borrow and no-borrow carry
    drive(32'h0000_0005, 32'h0000_0007, 1, 2'd2);
    drive(32'h0000_0007, 32'h0000_0007, 1, 2'd2);
    // boundary cross over all controls (R1 R2 R3 R4 R5 R7 R9)
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int c = 0; c < 8; c++)
          drive(edges[i], edges[j], c[0], c[2:1]);
    // random sweep
    for (int k = 0; k < 400; k++)
      drive($urandom, $urandom, 1'($urandom), 2'($urandom));
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule